// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm Match

This block keeps wall-clock time as a chain of four counters (seconds, minutes, hours, days) that advance on a slow one-cycle tick from an external prescaler. Software controls it through a small byte-wide register port: a run bit, a self-clearing clear command, three alarm compare registers (minute, hour, day), an interrupt enable and an interrupt factor flag. When the minute, hour and day counters come to equal the compare values, the factor flag is raised. The interrupt request is that flag gated by the enable.

The counters are deliberately outside the system reset. Time survives a chip reset, and only an explicit clear command issued while the timer is stopped sets it back to zero. No streaming data crosses this block, so every pin is a plain control or status signal with no valid/ready handshake. A register write takes effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`.

Top module: `rtc_alarm_timer`

## Requirements
- R1: Register map on `reg_addr`: 0 control (bit0 run, bit1 clear command), 1 seconds, 2 minutes, 3 hours, 4 days, 5 minute compare, 6 hour compare, 7 day compare, 8 interrupt (bit0 enable, bit1 factor flag). The clear bit always reads 0. A low `rst_n` clears run, enable, flag and all three compare registers.
- R2: Every clock edge that sees `tick` high while run is 1 advances time by one second. While run is 0, ticks have no effect.
- R3: Seconds and minutes wrap from 59 to 0, hours wrap from 23 to 0, and days wrap from 31 to 0. Each wrap carries one into the next counter.
- R4: A control write with bit1 = 1 and bit0 = 0, made while the timer is stopped, clears all four counters to 0 on that edge.
- R5: A clear command is ignored while the timer runs. A single control write with bit0 = 1 and bit1 = 1 to a stopped timer starts it and leaves the counters unchanged.
- R6: The counters keep their values through a low `rst_n`.
- R7: The minute compare register is 6 bits wide. The hour and day compare registers are 5 bits wide. Any value in range may be written, and higher register bits read back as 0. A minute compare above 59 never matches.
- R8: One cycle after the counters, or the compare registers, enter a state where minute, hour and day all equal their compare values, the factor flag is set. This happens once per entry into that state, including an entry caused by a clear command. The flag does not set again while the state persists.
- R9: Writing 1 to interrupt bit1 clears the flag. Writing 0 to it has no effect. A set in the same cycle wins over the clear.
- R10: `irq` is high exactly when the factor flag and the enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset (does not touch the counters) |
| tick | input | 1 | One-second pulse, one cycle wide |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Alarm interrupt request |

## Verification
On every cycle, assertions check the following: counter ranges; that counters hold while stopped; that a clear command zeroes them only when the timer is stopped and the write does not also start it; that a clear command during running changes nothing; and that every rise of the flag follows a cycle in which minute, hour and day matched their compares. Some behaviours can only be shown by bench scenarios: counters surviving a system reset, read-back masking of the compare registers, the minute and hour carries across a full hour and a full day, the flag being raised once per entry rather than on every matching tick, a match created by the clear itself, and the gating of `irq` by the enable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd2;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_DAY   = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMINS = 4'd5;
  localparam logic [ADDR_W-1:0] A_CHRS  = 4'd6;
  localparam logic [ADDR_W-1:0] A_CDAYS = 4'd7;
  localparam logic [ADDR_W-1:0] A_INT   = 4'd8;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int INT_EN_BIT   = 0;
  localparam int INT_FLG_BIT  = 1;
endpackage

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter #(
  parameter int MAXV = 59,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(MAXV);

  // No reset on purpose: time must outlive the system reset.
  always_ff @(posedge clk) begin
    if (clr)
      count <= '0;
    else if (inc)
      count <= (count == LAST) ? '0 : count + W'(1);
  end

  assign carry = inc && (count == LAST);
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int MW = 6,
  parameter int HW = 5,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] cur_min,
  input  logic [HW-1:0] cur_hour,
  input  logic [DW-1:0] cur_day,
  input  logic [MW-1:0] cmp_min,
  input  logic [HW-1:0] cmp_hour,
  input  logic [DW-1:0] cmp_day,
  input  logic          flag_w1c,
  output logic          flag
);
  logic match, match_q, set_evt;

  assign match   = (cur_min == cmp_min) && (cur_hour == cmp_hour) && (cur_day == cmp_day);
  assign set_evt = match && !match_q;

  // match_q starts high so the state found at reset is not taken as an entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b1;
      flag    <= 1'b0;
    end else begin
      match_q <= match;
      if (set_evt)
        flag <= 1'b1;
      else if (flag_w1c)
        flag <= 1'b0;
    end
  end

  AST_FLAG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(match)) else $error("flag rose without match"); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !match_q && flag_w1c) |=> flag) else $error("clear beat set"); // R9
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer #(
  parameter int SEC_MAX  = 59,
  parameter int MIN_MAX  = 59,
  parameter int HOUR_MAX = 23,
  parameter int DAY_MAX  = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       reg_wr,
  input  logic [rtc_pkg::ADDR_W-1:0] reg_addr,
  input  logic [rtc_pkg::DATA_W-1:0] reg_wdata,
  output logic [rtc_pkg::DATA_W-1:0] reg_rdata,
  output logic                       irq
);
  import rtc_pkg::*;

  localparam int SW = $clog2(SEC_MAX + 1);
  localparam int MW = $clog2(MIN_MAX + 1);
  localparam int HW = $clog2(HOUR_MAX + 1);
  localparam int DW = $clog2(DAY_MAX + 1);

  logic          run, int_en;
  logic [MW-1:0] cmp_min;
  logic [HW-1:0] cmp_hour;
  logic [DW-1:0] cmp_day;
  logic [SW-1:0] sec;
  logic [MW-1:0] mins;
  logic [HW-1:0] hours;
  logic [DW-1:0] days;
  logic          sec_c, min_c, hour_c, day_c;
  logic          flag;

  logic wr_ctrl, wr_int, clr_cnt, step;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_int  = reg_wr && (reg_addr == A_INT);
  // Clear only from the stopped state and only when this write does not start the timer.
  assign clr_cnt = wr_ctrl && reg_wdata[CTRL_CLR_BIT] && !run && !reg_wdata[CTRL_RUN_BIT];
  assign step    = tick && run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      int_en   <= 1'b0;
      cmp_min  <= '0;
      cmp_hour <= '0;
      cmp_day  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  run      <= reg_wdata[CTRL_RUN_BIT];
        A_CMINS: cmp_min  <= reg_wdata[MW-1:0];
        A_CHRS:  cmp_hour <= reg_wdata[HW-1:0];
        A_CDAYS: cmp_day  <= reg_wdata[DW-1:0];
        A_INT:   int_en   <= reg_wdata[INT_EN_BIT];
        default: ;
      endcase
    end
  end

  rtc_wrap_counter #(.MAXV(SEC_MAX)) u_sec (
    .clk(clk), .clr(clr_cnt), .inc(step), .count(sec), .carry(sec_c));
  rtc_wrap_counter #(.MAXV(MIN_MAX)) u_min (
    .clk(clk), .clr(clr_cnt), .inc(sec_c), .count(mins), .carry(min_c));
  rtc_wrap_counter #(.MAXV(HOUR_MAX)) u_hour (
    .clk(clk), .clr(clr_cnt), .inc(min_c), .count(hours), .carry(hour_c));
  rtc_wrap_counter #(.MAXV(DAY_MAX)) u_day (
    .clk(clk), .clr(clr_cnt), .inc(hour_c), .count(days), .carry(day_c));

  rtc_alarm_match #(.MW(MW), .HW(HW), .DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n),
    .cur_min(mins), .cur_hour(hours), .cur_day(days),
    .cmp_min(cmp_min), .cmp_hour(cmp_hour), .cmp_day(cmp_day),
    .flag_w1c(wr_int && reg_wdata[INT_FLG_BIT]),
    .flag(flag));

  assign irq = flag && int_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_RUN_BIT] = run;
      A_SEC:   reg_rdata = DATA_W'(sec);
      A_MIN:   reg_rdata = DATA_W'(mins);
      A_HOUR:  reg_rdata = DATA_W'(hours);
      A_DAY:   reg_rdata = DATA_W'(days);
      A_CMINS: reg_rdata = DATA_W'(cmp_min);
      A_CHRS:  reg_rdata = DATA_W'(cmp_hour);
      A_CDAYS: reg_rdata = DATA_W'(cmp_day);
      A_INT: begin
        reg_rdata[INT_EN_BIT]  = int_en;
        reg_rdata[INT_FLG_BIT] = flag;
      end
      default: ;
    endcase
  end

  AST_CLR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> !reg_rdata[CTRL_CLR_BIT]) else $error("clear bit visible"); // R1

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(reg_wr && reg_addr == A_CTRL)) |=> $stable({sec, mins, hours, days}))
    else $error("counted while stopped"); // R2

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step) && $past(sec) == SW'(SEC_MAX) |-> sec == '0) else $error("second wrap"); // R3

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hour_c) && $past(days) == DW'(DAY_MAX) |-> days == '0) else $error("day wrap"); // R3

  AST_CLEAR_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_CLR_BIT] && !reg_wdata[CTRL_RUN_BIT] && !run)
    |=> (sec == '0 && mins == '0 && hours == '0 && days == '0)) else $error("clear failed"); // R4

  AST_CLEAR_IGNORED_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL && reg_wdata[CTRL_CLR_BIT] && run && !tick)
    |=> $stable({sec, mins, hours, days})) else $error("clear while running"); // R5

  AST_DAY_CARRY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    day_c |-> hour_c) else $error("day carry without hour carry"); // R3
endmodule

// File: tb/rtc_alarm_timer_bench.sv
module rtc_alarm_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq;

  always #4 clk = ~clk;

  rtc_alarm_timer u_rtc_alarm_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  // Monitor: pops expected items and compares against what the design shows.
  always begin
    @(sample_ev);
    while (q.size() > 0) begin
      exp_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {7'd0, irq} : reg_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    exp_t it;
    @(negedge clk);
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = t;
    q.push_back(it);
    #2 -> sample_ev;
  endtask

  task automatic chk_irq(input logic e, input string t);
    exp_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = t;
    q.push_back(it);
    #2 -> sample_ev;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd(4'd0, 8'h00, "R1 control after reset");
    rd(4'd8, 8'h00, "R1 interrupt reg after reset");
    rd(4'd5, 8'h00, "R1 minute compare after reset");

    wr(4'd7, 8'd5);
    wr(4'd8, 8'h02);
    wr(4'd0, 8'h02);
    rd(4'd1, 8'd0, "R4 seconds cleared");
    rd(4'd2, 8'd0, "R4 minutes cleared");
    rd(4'd3, 8'd0, "R4 hours cleared");
    rd(4'd4, 8'd0, "R4 days cleared");

    ticks(3);
    rd(4'd1, 8'd0, "R2 no count while stopped");
    wr(4'd0, 8'h01);
    ticks(5);
    rd(4'd1, 8'd5, "R2 five ticks counted");
    rd(4'd0, 8'h01, "R1 run reads back, clear bit zero");

    wr(4'd0, 8'h03);
    rd(4'd1, 8'd5, "R5 clear ignored while running");
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h03);
    rd(4'd0, 8'h01, "R5 combined write starts timer");
    rd(4'd1, 8'd5, "R5 combined write does not clear");
    wr(4'd0, 8'h00);

    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    rd(4'd1, 8'd5, "R6 seconds survive system reset");
    rd(4'd0, 8'h00, "R1 run cleared by system reset");

    wr(4'd7, 8'd5);
    wr(4'd0, 8'h02);
    rd(4'd1, 8'd0, "R4 clear after system reset");

    wr(4'd5, 8'hFF); rd(4'd5, 8'h3F, "R7 minute compare masked");
    wr(4'd6, 8'hFF); rd(4'd6, 8'h1F, "R7 hour compare masked");
    wr(4'd7, 8'hFF); rd(4'd7, 8'h1F, "R7 day compare masked");

    wr(4'd5, 8'd1); wr(4'd6, 8'd0); wr(4'd7, 8'd0);
    wr(4'd8, 8'h03);
    rd(4'd8, 8'h01, "R8 no flag before match");
    wr(4'd0, 8'h01);
    ticks(59);
    rd(4'd1, 8'd59, "R3 seconds at 59");
    rd(4'd8, 8'h01, "R8 no flag at 0:00:59");
    ticks(1);
    rd(4'd1, 8'd0, "R3 seconds wrapped");
    rd(4'd2, 8'd1, "R3 minute carry");
    rd(4'd8, 8'h03, "R8 flag on alarm match");
    chk_irq(1'b1, "R10 irq with flag and enable");

    wr(4'd8, 8'h03);
    rd(4'd8, 8'h01, "R9 write-one clears flag");
    wr(4'd8, 8'h01);
    ticks(10);
    rd(4'd8, 8'h01, "R8 no re-set while match persists");

    wr(4'd0, 8'h00);
    wr(4'd5, 8'd0);
    wr(4'd8, 8'h00);
    rd(4'd8, 8'h00, "R8 no flag before clear");
    wr(4'd0, 8'h02);
    rd(4'd8, 8'h02, "R8 clear-created match sets flag");
    chk_irq(1'b0, "R10 irq blocked by enable");
    wr(4'd8, 8'h01);
    chk_irq(1'b1, "R10 irq once enabled");
    wr(4'd8, 8'h03);
    chk_irq(1'b0, "R9 irq falls after clear");

    wr(4'd7, 8'd5);
    wr(4'd0, 8'h01);
    ticks(3600);
    rd(4'd3, 8'd1, "R3 hour carry");
    rd(4'd2, 8'd0, "R3 minutes wrapped");
    rd(4'd1, 8'd0, "R3 seconds at hour boundary");

    wr(4'd0, 8'h00);
    wr(4'd0, 8'h02);
    wr(4'd0, 8'h01);
    ticks(86400);
    rd(4'd4, 8'd1, "R3 day carry");
    rd(4'd3, 8'd0, "R3 hours wrapped");

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule